// File: doc/BRIEF.md
# Aligned Clock-Enable Divider Bank

This block derives several slower rates from one source clock. Each of its dividers has a programmable ratio and emits a single-cycle tick (a clock enable) once per period. All ticks coincide on the cycle where every counter is at zero. Downstream logic runs on the source clock and qualifies its registers with a tick, so all divided domains stay edge-aligned.

New ratios are written into staged copies and do not touch the running dividers. A one-cycle `go` command commits them all at once. Once `go` is accepted, `go_busy` rises and every tick is held low. The block keeps the old counters running internally and lets them realign twice, which measures two least-common-multiple periods of the old divisors, then waits a fixed overhead. It then loads the new ratios, clears every counter on the same cycle and releases the ticks together. Software polls `go_busy` and must not issue a fresh `go` while it is high. Such a request is dropped.

Top module: `clkdiv_bank`

## Requirements
- R1: A ratio field holds the divisor minus one (0 means /1, 2 means /3, 11 means /12). Outside a transition, an enabled divider with divisor d asserts its tick on cycle k after a restart exactly when k mod d is 0.
- R2: After reset the divisors of dividers 0, 1 and 2 are /1, /3 and /6 with all enables set, and `go_busy` is low. In the first cycle after reset release all three ticks are high, and the pattern continues at a 1:3:6 rate.
- R3: A `go` sampled while `go_busy` is low makes `go_busy` high in the next cycle. `go_busy` never rises without a `go`.
- R4: `go_busy` stays high for exactly 2 × LCM(old divisors) + OVERHEAD cycles (OVERHEAD = 50), for example 62 cycles after /1,/3,/6 and 170 cycles after /4,/5,/3.
- R5: While `go_busy` is high every tick output is low.
- R6: In the first cycle with `go_busy` low after a transition, every enabled divider ticks together, and from then on each one follows its new divisor per R1.
- R7: A ratio write (`cfg_wr` high, `cfg_sel` = divider index) only updates the staged copy. The running divisor is unchanged until the next `go` transition ends.
- R8: A `go` sampled while `go_busy` is high is ignored and does not lengthen or shorten the transition.
- R9: The enable bit written with `cfg_en` (1 = enabled) takes effect in the cycle after the write, without staging. A cleared enable holds that divider's tick low while the other dividers keep their rhythm. The same write also stages `cfg_ratio` for that divider.
- R10: A write with `cfg_sel` not below the divider count (value 3 here) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for all dividers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW (2) | Divider index for the write |
| cfg_ratio | input | RW (4) | Divisor minus one, staged |
| cfg_en | input | 1 | Divider enable, applied directly |
| go | input | 1 | Commit request for staged ratios |
| go_busy | output | 1 | High while a commit transition runs |
| tick | output | NDIV (3) | Per-divider aligned clock-enable pulses |

## Verification
Ticks are decoded from registered counters, so after a restart they are due in the same cycle as the all-zero count. `go_busy` rises one cycle after the edge that samples `go`. A configuration write changes the enable state one cycle after its sampling edge. The bench drives inputs and samples outputs on falling edges, so each expectation is checked in the cycle after the edge that makes it due. Busy length is counted cycle by cycle from the first busy sample to the first idle one. Rates seen before a commit are counted over a 60-cycle window, which every old divisor divides, so the result does not depend on phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LAPS = 2'd1,
    SEQ_TAIL = 2'd2
  } seq_state_e;

  // Reset ratio (divisor minus one): /1 for index 0, then /3, /6, /12 ...
  function automatic int unsigned reset_ratio(input int unsigned idx);
    if (idx == 0) return 0;
    return 3 * (1 << (idx - 1)) - 1;
  endfunction

endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow #(
  parameter int NDIV = 3,
  parameter int RW   = 4,
  parameter int SELW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [SELW-1:0]           sel,
  input  logic [RW-1:0]             ratio,
  input  logic                      en_in,
  output logic [NDIV-1:0][RW-1:0]   staged,
  output logic [NDIV-1:0]           enables
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDIV; i++) begin
        staged[i]  <= RW'(clkdiv_pkg::reset_ratio(i));
        enables[i] <= 1'b1;
      end
    end else if (wr) begin
      for (int i = 0; i < NDIV; i++) begin
        if (sel == SELW'(i)) begin
          staged[i]  <= ratio;
          enables[i] <= en_in;
        end
      end
    end
  end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int          RW          = 4,
  parameter logic [RW-1:0] RESET_RATIO = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [RW-1:0] new_ratio,
  output logic          at_zero
);

  logic [RW-1:0] act_q;
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RESET_RATIO;
      cnt_q <= '0;
    end else begin
      if (load) act_q <= new_ratio;
      if (clear)               cnt_q <= '0;
      else if (cnt_q == act_q) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_goseq.sv
module clkdiv_goseq #(
  parameter int OVERHEAD = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic all_zero,
  output logic busy,
  output logic restart,
  output logic commit
);
  import clkdiv_pkg::*;

  localparam int TW = (OVERHEAD > 2) ? $clog2(OVERHEAD) : 1;

  seq_state_e    state_q;
  logic [1:0]    laps_q;
  logic [TW-1:0] tail_q;

  assign busy    = (state_q != SEQ_IDLE);
  assign restart = go && (state_q == SEQ_IDLE);
  assign commit  = (state_q == SEQ_TAIL) && (tail_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      laps_q  <= '0;
      tail_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (go) begin
            state_q <= SEQ_LAPS;
            laps_q  <= '0;
          end
        end
        SEQ_LAPS: begin
          // third all-zero (counting the restart cycle) ends two full periods
          if (all_zero) begin
            if (laps_q == 2'd2) begin
              state_q <= SEQ_TAIL;
              tail_q  <= TW'(OVERHEAD - 2);
            end else begin
              laps_q <= laps_q + 2'd1;
            end
          end
        end
        SEQ_TAIL: begin
          if (tail_q == '0) state_q <= SEQ_IDLE;
          else              tail_q  <= tail_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NDIV     = 3,
  parameter int RW       = 4,
  parameter int OVERHEAD = 50,
  parameter int SELW     = (NDIV > 1) ? $clog2(NDIV + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [RW-1:0]   cfg_ratio,
  input  logic            cfg_en,
  input  logic            go,
  output logic            go_busy,
  output logic [NDIV-1:0] tick
);

  logic [NDIV-1:0][RW-1:0] staged;
  logic [NDIV-1:0]         en_cur;
  logic [NDIV-1:0]         at_zero;
  logic                    all_zero;
  logic                    restart;
  logic                    commit;

  clkdiv_shadow #(.NDIV(NDIV), .RW(RW), .SELW(SELW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .sel     (cfg_sel),
    .ratio   (cfg_ratio),
    .en_in   (cfg_en),
    .staged  (staged),
    .enables (en_cur)
  );

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    clkdiv_counter #(
      .RW          (RW),
      .RESET_RATIO (RW'(clkdiv_pkg::reset_ratio(g)))
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (restart | commit),
      .load      (commit),
      .new_ratio (staged[g]),
      .at_zero   (at_zero[g])
    );
  end

  assign all_zero = &at_zero;

  clkdiv_goseq #(.OVERHEAD(OVERHEAD)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .all_zero (all_zero),
    .busy     (go_busy),
    .restart  (restart),
    .commit   (commit)
  );

  assign tick = {NDIV{~go_busy}} & en_cur & at_zero;

endmodule

// File: rtl/clkdiv_bank_sva.sv
module clkdiv_bank_sva #(
  parameter int NDIV = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic            go_busy,
  input logic [NDIV-1:0] tick,
  input logic [NDIV-1:0] en_now
);

  assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !go_busy) |=> go_busy);

  assert_busy_needs_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_busy) |-> $past(go));

  assert_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_busy |-> (tick == '0));

  assert_aligned_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_busy) |-> (tick == en_now));

endmodule

bind clkdiv_bank clkdiv_bank_sva #(.NDIV(NDIV)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go),
  .go_busy (go_busy),
  .tick    (tick),
  .en_now  (en_cur)
);

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [3:0] cfg_ratio = '0;
  logic       cfg_en = 1'b1;
  logic       go = 1'b0;
  logic       go_busy;
  logic [2:0] tick;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clkdiv_bank u_clkdiv_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_ratio (cfg_ratio),
    .cfg_en    (cfg_en),
    .go        (go),
    .go_busy   (go_busy),
    .tick      (tick)
  );

  // {ratio0, ratio1, ratio2, expected busy length from previous divisors}
  localparam int VEC [5][4] = '{
    '{1, 5, 11, 62},
    '{0, 0, 0, 74},
    '{3, 4, 2, 52},
    '{1, 1, 1, 170},
    '{0, 2, 5, 54}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int sel, input int ratio, input bit en);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_ratio = 4'(ratio); cfg_en = en;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Ends at the negedge of the first idle cycle after the transition.
  task automatic run_go(input int exp_len, input string req, input int extra_at);
    int  len;
    bit  paused_ok;
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(go_busy == 1'b1, "R3 busy after go", int'(go_busy), 1);
    len = 1;
    paused_ok = (tick == 3'b000);
    while (1) begin
      if (extra_at > 0 && len == extra_at) go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      if (!go_busy || len > 1000) break;
      len++;
      if (tick != 3'b000) paused_ok = 1'b0;
    end
    chk(paused_ok, "R5 ticks low while busy", 0, 0);
    chk(len == exp_len, req, len, exp_len);
  endtask

  // Starts at the negedge that is cycle k=0 of a restart.
  task automatic check_pattern(input int d0, input int d1, input int d2,
                               input string req, input int cycles);
    int d [3];
    bit ok [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    for (int i = 0; i < 3; i++) ok[i] = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) @(negedge clk);
      for (int i = 0; i < 3; i++)
        if (tick[i] != ((k % d[i]) == 0)) ok[i] = 1'b0;
    end
    for (int i = 0; i < 3; i++) chk(ok[i], req, i, d[i]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int old [3];
    int cnt [3];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state and default 1:3:6 rhythm from the release cycle
    chk(go_busy == 1'b0, "R2 busy low after reset", int'(go_busy), 0);
    chk(tick == 3'b111, "R2 all ticks at release", int'(tick), 7);
    check_pattern(1, 3, 6, "R2 default pattern", 12);

    old[0] = 1; old[1] = 3; old[2] = 6;
    for (int v = 0; v < 5; v++) begin
      for (int i = 0; i < 3; i++) wr_cfg(i, VEC[v][i], 1'b1);
      // R7: staged writes leave the running rate untouched
      for (int i = 0; i < 3; i++) cnt[i] = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cnt[i] += int'(tick[i]);
      end
      for (int i = 0; i < 3; i++)
        chk(cnt[i] == 60 / old[i], "R7 old rate before go", cnt[i], 60 / old[i]);
      run_go(VEC[v][3], "R4 busy length", 0);
      chk(tick == 3'b111, "R6 aligned restart", int'(tick), 7);
      check_pattern(VEC[v][0] + 1, VEC[v][1] + 1, VEC[v][2] + 1, "R1 divided rhythm", 24);
      for (int i = 0; i < 3; i++) old[i] = VEC[v][i] + 1;
    end

    // R8: an extra go in the middle of a transition is dropped
    run_go(62, "R8 busy length with ignored go", 10);
    chk(tick == 3'b111, "R8 aligned restart", int'(tick), 7);
    check_pattern(1, 3, 6, "R8 rhythm after ignored go", 12);

    // R10: out-of-range select writes nothing
    wr_cfg(3, 7, 1'b0);
    run_go(62, "R10 busy length", 0);
    chk(tick == 3'b111, "R10 enables intact", int'(tick), 7);
    check_pattern(1, 3, 6, "R10 ratios intact", 12);

    // R9: enable gates one divider at once, others keep going
    wr_cfg(0, 0, 1'b0);
    for (int i = 0; i < 3; i++) cnt[i] = 0;
    for (int c = 0; c < 6; c++) begin
      if (c > 0) @(negedge clk);
      for (int i = 0; i < 3; i++) cnt[i] += int'(tick[i]);
    end
    chk(cnt[0] == 0, "R9 disabled divider silent", cnt[0], 0);
    chk(cnt[1] == 2, "R9 neighbour keeps rate", cnt[1], 2);
    wr_cfg(0, 0, 1'b1);
    cnt[0] = 0;
    for (int c = 0; c < 4; c++) begin
      if (c > 0) @(negedge clk);
      cnt[0] += int'(tick[0]);
    end
    chk(cnt[0] == 4, "R9 re-enabled divider ticks", cnt[0], 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule